// File: doc/BRIEF.md
# Multi-Depth Video Pixel Streamer

This block reads a run of pixels from a 32-bit-wide memory read port and sends them to four 8-bit DAC lanes at a pixel rate set by an integer divider of the system clock. A single start command sets the pixel depth, the divider, the pixel count and the first word address. The block then fetches words in ascending address order, splits them into pixels starting at the least significant bits, and shows each pixel for N system clocks.

Pixels of 32 and 16 bits go straight to the lanes. Pixels of 8, 4, 2 and 1 bits are indices into a 256 x 32 palette RAM, and the RAM entry becomes the lane pattern. When no stream is running, the lanes show a four-byte default register, so software can produce sync and blanking levels by writing that register and waiting. The palette is loaded one entry per clock through a write port while the block is idle.

Top module: `pix_streamer`

## Requirements
- R1: After reset `busy_o` is 0, `rd_req_o` is 0, the default register holds zero, and whenever `busy_o` is 0 `dac_o` equals the default register (lane k on bits 8k+7..8k).
- R2: A write on `dflt_we_i` stores `dflt_data_i` at that clock edge, and the idle output shows the new value from the next cycle.
- R3: Mode code 0 is 32-bit direct: each fetched word is one pixel and drives all four lanes unchanged.
- R4: Mode code 1 is 16-bit direct: two pixels per word, low half first. A pixel drives lanes 0 and 1 with its low and high bytes, and lanes 2 and 3 show the default register.
- R5: Mode codes 2, 3, 4 and 5 take 8-, 4-, 2- and 1-bit pixels, least significant first within each word (4, 8, 16 or 32 per word). Each pixel value is the palette address, and the 32-bit entry at that address is output.
- R6: A palette write stores `pal_data_i` at `pal_addr_i`, one entry per clock, only while `busy_o` is 0. A write while busy has no effect.
- R7: With `div_i` = N-1, the first pixel appears N cycles after the edge that samples the first word's `rd_valid_i`, and each pixel is held for exactly N cycles.
- R8: Reads start at `addr_i` and step by +1 per word. There is at most one outstanding read, and the stream makes exactly ceil(count/pixels-per-word) requests.
- R9: The next word is prefetched while the current one shifts out, so the pixels are gap-free whenever read latency + 1 < N x pixels-per-word.
- R10: `busy_o` rises the cycle after an accepted start and falls N cycles after the last pixel appears. At that point the output reverts to the default register, and no read is requested while idle.
- R11: A start is ignored while busy, with mode code 6 or 7, or with a count of 0.
- R12: Back-to-back streams show the default register during the cycles between the end of one run and the first pixel of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a stream |
| mode_i | input | 3 | Pixel depth code |
| div_i | input | DIV_W | Pixel period minus one, in clocks |
| count_i | input | CNT_W | Number of pixels |
| addr_i | input | ADDR_W | First word address |
| rd_req_o | output | 1 | Read request, one cycle per word |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data word |
| dflt_we_i | input | 1 | Default register write |
| dflt_data_i | input | 32 | Default lane values |
| pal_we_i | input | 1 | Palette write |
| pal_addr_i | input | PAL_AW | Palette write address |
| pal_data_i | input | 32 | Palette write data |
| dac_o | output | 32 | Four DAC lanes, lane k on bits 8k+7..8k |
| busy_o | output | 1 | Stream in progress |

## Verification
The assertions check on every cycle the protocol-level behaviours: an idle output equal to a mirrored default register, a single outstanding read, addresses that step by one within a stream, no requests while idle, and busy rising only after a start. Pixel content and ordering per depth, the N-cycle hold, gap-free prefetch, the exact fall time of busy and the rejection of palette writes or starts while busy are visible only to the bench. It compares every output cycle against an arithmetic model of memory and palette across all depths, several dividers and latencies, and counts at the word boundaries.

// File: rtl/pix_stream_pkg.sv
`timescale 1ns/1ps
package pix_stream_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    PM_D32 = 3'd0,
    PM_D16 = 3'd1,
    PM_P8  = 3'd2,
    PM_P4  = 3'd3,
    PM_P2  = 3'd4,
    PM_P1  = 3'd5
  } pix_mode_e;

  // log2 of pixels per word
  function automatic logic [2:0] ppw_log2(input logic [2:0] m);
    case (m)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic mode_ok(input logic [2:0] m);
    return m <= 3'd5;
  endfunction
endpackage

// File: rtl/pix_rate_div.sv
`timescale 1ns/1ps
module pix_rate_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && !hold_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else if (cnt_q != div_i)  cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/pix_fetch.sv
`timescale 1ns/1ps
module pix_fetch #(
  parameter int ADDR_W = 16,
  parameter int WCNT_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [WCNT_W-1:0] words_i,
  input  logic              consume_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic              got_o,
  output logic              nxt_vld_o,
  output logic [31:0]       nxt_data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] left_q;
  logic              pend_q;
  logic              vld_q;
  logic [31:0]       data_q;

  assign rd_req_o   = (left_q != '0) && !pend_q && !vld_q;
  assign rd_addr_o  = addr_q;
  assign got_o      = pend_q && rd_valid_i;
  assign nxt_vld_o  = vld_q;
  assign nxt_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      left_q <= words_i;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (rd_req_o) begin
        pend_q <= 1'b1;
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - WCNT_W'(1);
      end
      if (got_o) begin
        pend_q <= 1'b0;
        vld_q  <= 1'b1;
        data_q <= rd_data_i;
      end
      if (consume_i) vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_unpack.sv
`timescale 1ns/1ps
module pix_unpack
  import pix_stream_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [2:0]  mode_i,
  input  logic        emit_i,
  input  logic [31:0] nxt_data_i,
  output logic        need_o,
  output logic [31:0] raw_o
);
  logic [31:0] cur_q;
  logic [5:0]  cnt_q;
  logic [2:0]  lg;
  logic [2:0]  bpp_lg;
  logic [5:0]  bpp;
  logic [31:0] mask;
  logic [31:0] src;

  assign lg     = ppw_log2(mode_i);
  assign bpp_lg = 3'd5 - lg;
  assign bpp    = 6'd1 << bpp_lg;
  assign mask   = (bpp_lg == 3'd5) ? '1 : ((32'd1 << bpp) - 32'd1);
  assign need_o = (cnt_q == '0);
  assign src    = need_o ? nxt_data_i : cur_q;
  assign raw_o  = src & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (emit_i) begin
      if (need_o) begin
        cur_q <= nxt_data_i >> bpp;
        cnt_q <= (6'd1 << lg) - 6'd1;
      end else begin
        cur_q <= cur_q >> bpp;
        cnt_q <= cnt_q - 6'd1;
      end
    end
  end
endmodule

// File: rtl/pix_palette.sv
`timescale 1ns/1ps
module pix_palette #(
  parameter int PAL_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAL_AW-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic              direct_i,
  input  logic              emit_i,
  input  logic [31:0]       raw_i,
  output logic [31:0]       pix_o
);
  localparam int PAL_DEPTH = 1 << PAL_AW;

  logic [31:0] mem_q [PAL_DEPTH];
  logic [31:0] pix_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // single registered stage: lookup or pass-through
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pix_q <= '0;
    else if (emit_i) pix_q <= direct_i ? raw_i : mem_q[raw_i[PAL_AW-1:0]];
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/pix_streamer.sv
`timescale 1ns/1ps
module pix_streamer
  import pix_stream_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DIV_W  = 6,
  parameter int PAL_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  input  logic              dflt_we_i,
  input  logic [31:0]       dflt_data_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_addr_i,
  input  logic [31:0]       pal_data_i,
  output logic [31:0]       dac_o,
  output logic              busy_o
);
  localparam int WCNT_W = CNT_W + 1;

  logic              busy_q, run_q, shown_q;
  logic [2:0]        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  left_q;
  logic [31:0]       dflt_q;
  logic              accept, tick, emit, finish, hold, need, consume, got, nxt_vld;
  logic [31:0]       nxt_data, raw, pix;
  logic [2:0]        lg_in;
  logic [WCNT_W-1:0] words;

  assign lg_in   = ppw_log2(mode_i);
  assign accept  = start_i && !busy_q && mode_ok(mode_i) && (count_i != '0);
  assign words   = (WCNT_W'(count_i) + (WCNT_W'(1) << lg_in) - WCNT_W'(1)) >> lg_in;
  assign emit    = tick && (left_q != '0);
  assign finish  = tick && (left_q == '0);
  assign hold    = need && !nxt_vld && (left_q != '0);
  assign consume = emit && need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      run_q   <= 1'b0;
      shown_q <= 1'b0;
      mode_q  <= '0;
      div_q   <= '0;
      left_q  <= '0;
      dflt_q  <= '0;
    end else begin
      if (dflt_we_i) dflt_q <= dflt_data_i;
      if (accept) begin
        busy_q  <= 1'b1;
        run_q   <= 1'b0;
        shown_q <= 1'b0;
        mode_q  <= mode_i;
        div_q   <= div_i;
        left_q  <= count_i;
      end else begin
        if (busy_q && !run_q && got) run_q <= 1'b1;
        if (emit) begin
          left_q  <= left_q - CNT_W'(1);
          shown_q <= 1'b1;
        end
        if (finish) begin
          busy_q <= 1'b0;
          run_q  <= 1'b0;
        end
      end
    end
  end

  pix_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .hold_i (hold),
    .div_i  (div_q),
    .tick_o (tick)
  );

  pix_fetch #(.ADDR_W(ADDR_W), .WCNT_W(WCNT_W)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .base_i     (addr_i),
    .words_i    (words),
    .consume_i  (consume),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .got_o      (got),
    .nxt_vld_o  (nxt_vld),
    .nxt_data_o (nxt_data)
  );

  pix_unpack u_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .mode_i     (mode_q),
    .emit_i     (emit),
    .nxt_data_i (nxt_data),
    .need_o     (need),
    .raw_o      (raw)
  );

  pix_palette #(.PAL_AW(PAL_AW)) u_pal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pal_we_i && !busy_q),
    .waddr_i  (pal_addr_i),
    .wdata_i  (pal_data_i),
    .direct_i (mode_q < 3'd2),
    .emit_i   (emit),
    .raw_i    (raw),
    .pix_o    (pix)
  );

  always_comb begin
    dac_o = dflt_q;
    if (busy_q && shown_q) begin
      dac_o = pix;
      if (mode_q == PM_D16) dac_o[31:16] = dflt_q[31:16];
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pix_streamer_chk.sv
`timescale 1ns/1ps
module pix_streamer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              dflt_we_i,
  input logic [31:0]       dflt_data_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic [31:0]       dac_o,
  input logic              busy_o
);
  logic [31:0]       dflt_m;
  logic              pend_m;
  logic              seen_m;
  logic [ADDR_W-1:0] next_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dflt_m <= '0;
      pend_m <= 1'b0;
      seen_m <= 1'b0;
      next_m <= '0;
    end else begin
      if (dflt_we_i) dflt_m <= dflt_data_i;
      if (rd_req_o) pend_m <= 1'b1;
      else if (rd_valid_i) pend_m <= 1'b0;
      if (!busy_o) seen_m <= 1'b0;
      else if (rd_req_o) seen_m <= 1'b1;
      if (rd_req_o) next_m <= rd_addr_o + ADDR_W'(1);
    end
  end

  AST_IDLE_DFLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> dac_o == dflt_m); // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pend_m); // R8
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && seen_m |-> rd_addr_o == next_m); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
endmodule

bind pix_streamer pix_streamer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dflt_we_i   (dflt_we_i),
  .dflt_data_i (dflt_data_i),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .dac_o       (dac_o),
  .busy_o      (busy_o)
);

// File: tb/pix_streamer_tb_top.sv
`timescale 1ns/1ps
module pix_streamer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [5:0]  div = '0;
  logic [11:0] count = '0;
  logic [15:0] addr = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        dflt_we = 1'b0;
  logic [31:0] dflt_data = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [31:0] pal_data = '0;
  logic [31:0] dac;
  logic        busy;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] pal_m [256];
  logic [31:0] dflt_m = '0;
  int lat = 1;
  int ctr = 0;
  logic [15:0] ma;
  int req_cnt = 0;
  int addr_err = 0;
  logic [15:0] exp_addr = '0;

  always #2 clk = ~clk;

  pix_streamer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .div_i(div),
    .count_i(count), .addr_i(addr), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .dflt_we_i(dflt_we),
    .dflt_data_i(dflt_data), .pal_we_i(pal_we), .pal_addr_i(pal_addr),
    .pal_data_i(pal_data), .dac_o(dac), .busy_o(busy)
  );

  function automatic logic [31:0] mword(input logic [15:0] a);
    return {16'h0, a} * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  function automatic logic [31:0] pval(input int i);
    return {8'(i) ^ 8'h3C, 8'(255 - i), 8'(i * 7), 8'(i)};
  endfunction

  function automatic int plg(input int m);
    return (m > 5) ? 5 : m;
  endfunction

  function automatic logic [31:0] exp_raw(input int m, input int i, input int base);
    int lg = plg(m);
    int bpp = 32 >> lg;
    logic [31:0] w, r;
    w = mword(16'(base + (i >> lg)));
    r = w >> ((i & ((1 << lg) - 1)) * bpp);
    if (bpp < 32) r = r & ((32'd1 << bpp) - 32'd1);
    return r;
  endfunction

  function automatic logic [31:0] exp_pix(input int m, input int i, input int base);
    logic [31:0] r = exp_raw(m, i, base);
    if (m == 0) return r;
    if (m == 1) return {dflt_m[31:16], r[15:0]};
    return pal_m[r[7:0]];
  endfunction

  // memory model: fixed latency, one word per request
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ctr = 0;
    end else begin
      rd_valid <= 1'b0;
      if (rd_req) begin
        req_cnt++;
        if (rd_addr != exp_addr) addr_err++;
        exp_addr = rd_addr + 16'd1;
        if (lat == 1) begin
          rd_valid <= 1'b1;
          rd_data  <= mword(rd_addr);
        end else begin
          ctr = lat - 1;
          ma  = rd_addr;
        end
      end else if (ctr > 0) begin
        ctr--;
        if (ctr == 0) begin
          rd_valid <= 1'b1;
          rd_data  <= mword(ma);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic write_dflt(input logic [31:0] v);
    @(negedge clk);
    dflt_we = 1'b1; dflt_data = v; dflt_m = v;
    @(negedge clk);
    dflt_we = 1'b0;
  endtask

  task automatic load_pal();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(i); pal_data = pval(i); pal_m[i] = pval(i);
    end
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  // poke: 0 none, 1 start while busy, 2 palette write while busy
  task automatic run_stream(input int m, input int nn, input int cnt, input int base,
                            input int l, input int poke);
    int first, last_end, bad_d, bad_b, ppw, words;
    logic [31:0] e;
    logic eb;
    string tag;
    tag = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    ppw = 1 << plg(m);
    words = (cnt + ppw - 1) / ppw;
    bad_d = 0; bad_b = 0;
    @(negedge clk);
    lat = l; req_cnt = 0; addr_err = 0; exp_addr = 16'(base);
    start = 1'b1; mode = 3'(m); div = 6'(nn - 1); count = 12'(cnt); addr = 16'(base);
    first = 1 + l + nn;
    last_end = 1 + l + nn * (cnt + 1);
    for (int j = 0; j <= last_end + 1; j++) begin
      @(negedge clk);
      if (j == 0) start = 1'b0;
      if (j == 2 && poke == 1) begin
        start = 1'b1; mode = 3'd5; count = 12'd1; addr = 16'(base + 100);
      end
      if (j == 2 && poke == 2) begin
        pal_we = 1'b1; pal_addr = exp_raw(m, 0, base) & 32'hFF;
        pal_data = ~pal_m[exp_raw(m, 0, base) & 32'hFF];
      end
      if (j == 3) begin
        start = 1'b0; pal_we = 1'b0;
      end
      e  = (j >= first && j < last_end) ? exp_pix(m, (j - first) / nn, base) : dflt_m;
      eb = (j < last_end);
      if (dac !== e) begin
        if (bad_d == 0)
          $display("FAIL %s R7 R9 mode=%0d N=%0d lat=%0d j=%0d got=%h exp=%h",
                   tag, m, nn, l, j, dac, e);
        bad_d++;
      end
      if (busy !== eb) begin
        if (bad_b == 0)
          $display("FAIL R10 busy mode=%0d N=%0d j=%0d got=%0b exp=%0b", m, nn, j, busy, eb);
        bad_b++;
      end
    end
    n_tests += 2;
    if (bad_d != 0) n_fail++;
    if (bad_b != 0) n_fail++;
    chk(req_cnt == words && addr_err == 0, "R8 request count/address",
        32'(req_cnt), 32'(words));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ppw;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    chk(dac == 32'h0, "R1 dac after reset", dac, 0);
    chk(rd_req == 1'b0, "R1 rd_req after reset", 32'(rd_req), 0);
    rst_n = 1'b1;

    write_dflt(32'h4030_2010);
    chk(dac == 32'h4030_2010, "R2 idle default", dac, 32'h4030_2010);
    write_dflt(32'hC3A5_0F81);
    chk(dac == 32'hC3A5_0F81, "R2 idle default rewrite", dac, 32'hC3A5_0F81);

    load_pal();

    // R11: reserved mode and zero count are rejected
    @(negedge clk); start = 1'b1; mode = 3'd6; count = 12'd5; div = '0;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0 && rd_req == 1'b0, "R11 mode 6 ignored", 32'(busy), 0);
    @(negedge clk); start = 1'b1; mode = 3'd7; count = 12'd5;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0 && rd_req == 1'b0, "R11 mode 7 ignored", 32'(busy), 0);
    @(negedge clk); start = 1'b1; mode = 3'd2; count = 12'd0;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0 && rd_req == 1'b0, "R11 zero count ignored", 32'(busy), 0);
    chk(dac == dflt_m, "R11 output stays default", dac, dflt_m);

    // sweep depths, dividers and latencies within the gap-free condition (R9)
    for (int m = 0; m < 6; m++) begin
      for (int nn = 1; nn <= 4; nn++) begin
        for (int l = 1; l <= 3; l++) begin
          ppw = 1 << plg(m);
          if (l + 1 < nn * ppw) begin
            run_stream(m, nn, 1, m * 512 + nn * 64 + l * 16, l, 0);
            run_stream(m, nn, ppw + 1, m * 512 + nn * 64 + l * 16 + 3, l, 0);
            run_stream(m, nn, 3 * ppw - 1, m * 512 + nn * 64 + l * 16 + 7, l, 0);
          end
        end
      end
    end

    // R11: start while busy has no effect on the running stream
    run_stream(2, 2, 20, 3000, 2, 1);
    // R6: palette write while busy is dropped; rerun shows the old entry
    run_stream(2, 1, 12, 3400, 1, 2);
    run_stream(2, 1, 12, 3400, 1, 0);

    // R4: lanes 2/3 follow a changed default register
    write_dflt(32'h7E6D_0000);
    run_stream(1, 3, 9, 3600, 2, 0);

    // R12: back-to-back streams, default shown in between
    run_stream(3, 2, 16, 3800, 1, 0);
    run_stream(0, 5, 4, 3900, 3, 0);
    run_stream(5, 1, 40, 4000, 2, 0);

    @(negedge clk);
    chk(busy == 1'b0 && dac == dflt_m, "R10 idle after final stream", dac, dflt_m);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule